// File: doc/BRIEF.md
# Low-Frequency Oscillator Control and Start-Up Timer

This block holds the 32-bit control word for an on-chip low-frequency oscillator and turns it into control pins for the analog core and the clock tree. A simple register bus writes and reads the word at one address. The fields hold a 7-bit trim value, a start-up delay selector, two sleep-policy bits, two output-enable bits, the oscillator enable, and a write lock that stays set once written.

When the oscillator enable is set, a start-up timer counts edges of a separate always-on low-power clock. Each such edge is presented to this block as a one-cycle strobe, `lp_tick`, in the bus clock domain. The timer raises `osc_ready` once the selected number of edges has arrived. The selectable delays grow roughly as powers of two. The two clock-enable outputs are forced low until `osc_ready` is high. The sleep-policy bits are stored and brought out as pins. They have no effect inside the block.

Top module: `osc_ctl_top`

## Requirements
- R1: After reset the register reads 0x003F0080: trim value 0x3F, on-demand bit 1, every other bit 0. `osc_ready`, `clk_main_en` and `clk_div_en` are low.
- R2: Field positions are trim value 22:16, lock 12, start-up select 10:8, on-demand 7, run-in-standby 6, divided-output enable 3, main-output enable 2, oscillator enable 1. While unlocked, a write sets each field to the matching bits of the write data.
- R3: Bits 0, 4, 5, 11, 13-15 and 23-31 always read as 0, whatever was written to them. The writable mask is 0x007F17CE.
- R4: The register sits at address `REG_ADDR`. Writes to any other address change nothing, and reads at any other address return 0.
- R5: A write that sets bit 12 also applies the other fields it carries. After that, every write is ignored and the lock cannot be cleared, until reset.
- R6: The start-up delay is the table value selected by bits 10:8 plus 3 edges. The table values for codes 0 to 7 are 3, 4, 6, 10, 18, 34, 66 and 130, so the totals are 6, 7, 9, 13, 21, 37, 69 and 133 `lp_tick` strobes after the enable takes effect.
- R7: The start-up timer advances only on bus-clock cycles where `lp_tick` is high. Idle cycles leave it unchanged.
- R8: Clearing the oscillator enable drops `osc_ready` on the same clock edge that updates the register, and clears the timer. Setting the enable again restarts the full delay.
- R9: `clk_main_en` equals `osc_ready` AND bit 2. `clk_div_en` equals `osc_ready` AND bit 3.
- R10: `osc_en`, `calib_val`, `ondemand_o` and `stdby_run_o` follow bit 1, bits 22:16, bit 7 and bit 6 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| lp_tick | input | 1 | One-cycle strobe for each edge of the low-power clock |
| osc_en | output | 1 | Enable to the analog oscillator |
| osc_ready | output | 1 | Start-up delay has elapsed |
| clk_main_en | output | 1 | Gated enable for the full-rate output |
| clk_div_en | output | 1 | Gated enable for the divided-rate output |
| calib_val | output | 7 | Trim value to the oscillator |
| ondemand_o | output | 1 | Stored on-demand policy bit |
| stdby_run_o | output | 1 | Stored run-in-standby policy bit |

## Verification
The bench runs every start-up code and checks `osc_ready` one strobe before the expected count and again at the count. An off-by-one in the timer, a wrong table entry, or a missing extra three edges would show up as ready rising early or late. It removes the enable both while the timer is counting and after ready is high, then re-enables and counts again. A timer that was not cleared would reach ready too soon, and a ready signal not gated by the enable would linger. It also sets the lock together with other fields and then tries to overwrite and unlock. A design that dropped the fields in the locking write, or that let the lock be cleared, gives the wrong readback. Random writes to random addresses check the field masks, the address decode, and that the clock enables stay low without strobes.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned CAL_W  = 7;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned EXTRA_EDGES = 3;

  localparam logic [DATA_W-1:0] CFG_MASK  = 32'h007F_17CE;
  localparam logic [DATA_W-1:0] CFG_RESET = 32'h003F_0080;

  typedef struct packed {
    logic [CAL_W-1:0] trim;
    logic             lock;
    logic [SEL_W-1:0] sel;
    logic             ondemand;
    logic             stdby_run;
    logic             div_en;
    logic             main_en;
    logic             enable;
  } cfg_t;

  function automatic cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
    cfg_t c;
    c.trim      = w[22:16];
    c.lock      = w[12];
    c.sel       = w[10:8];
    c.ondemand  = w[7];
    c.stdby_run = w[6];
    c.div_en    = w[3];
    c.main_en   = w[2];
    c.enable    = w[1];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_to_word(input cfg_t c);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[22:16] = c.trim;
    w[12]    = c.lock;
    w[10:8]  = c.sel;
    w[7]     = c.ondemand;
    w[6]     = c.stdby_run;
    w[3]     = c.div_en;
    w[2]     = c.main_en;
    w[1]     = c.enable;
    return w;
  endfunction

  // Table entry is 2 + 2**sel; the total adds the fixed extra edges.
  function automatic int unsigned startup_edges(input logic [SEL_W-1:0] sel);
    return 2 + (32'd1 << sel) + EXTRA_EDGES;
  endfunction

endpackage

// File: rtl/osc_ctl_regs.sv
module osc_ctl_regs
  import osc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg_q
);

  cfg_t cfg_d;
  logic wr_ok;

  assign wr_ok = wr_hit && !cfg_q.lock;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_ok) begin
      cfg_d = cfg_from_word(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= cfg_from_word(CFG_RESET);
    end else if (wr_ok) begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/osc_ctl_startup.sv
module osc_ctl_startup
  import osc_ctl_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             ready
);

  logic [CNT_W-1:0] cnt_q, cnt_d, target, cnt_inc;
  logic             rdy_q, rdy_d;
  logic             cnt_ce;

  assign target  = CNT_W'(startup_edges(sel));
  assign cnt_inc = cnt_q + 1'b1;
  assign cnt_ce  = !run || (tick && !rdy_q);

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!run) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (tick && !rdy_q) begin
      cnt_d = cnt_inc;
      if (cnt_inc >= target) begin
        rdy_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q && run;

endmodule

// File: rtl/osc_ctl_gate.sv
module osc_ctl_gate #(
  parameter int unsigned N_OUT = 2
) (
  input  logic             ready,
  input  logic [N_OUT-1:0] req,
  output logic [N_OUT-1:0] gated
);

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    assign gated[g] = ready && req[g];
  end

endmodule

// File: rtl/osc_ctl_top.sv
module osc_ctl_top
  import osc_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned REG_ADDR = 'h18,
  parameter int unsigned CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              lp_tick,
  output logic              osc_en,
  output logic              osc_ready,
  output logic              clk_main_en,
  output logic              clk_div_en,
  output logic [6:0]        calib_val,
  output logic              ondemand_o,
  output logic              stdby_run_o
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              addr_hit;
  logic              wr_hit;
  cfg_t              cfg_q;
  logic [DATA_W-1:0] cfg_word;
  logic [1:0]        out_gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign addr_hit = (bus_addr == HIT_ADDR);
  assign wr_hit   = bus_we && addr_hit;

  osc_ctl_regs i_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_hit(wr_hit),
    .wdata (bus_wdata),
    .cfg_q (cfg_q)
  );

  assign cfg_word  = cfg_to_word(cfg_q);
  assign bus_rdata = addr_hit ? cfg_word : '0;

  osc_ctl_startup #(.CNT_W(CNT_W)) i_startup (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .run  (cfg_q.enable),
    .tick (lp_tick),
    .sel  (cfg_q.sel),
    .ready(osc_ready)
  );

  osc_ctl_gate #(.N_OUT(2)) i_gate (
    .ready(osc_ready),
    .req  ({cfg_q.div_en, cfg_q.main_en}),
    .gated(out_gated)
  );

  assign clk_main_en = out_gated[0];
  assign clk_div_en  = out_gated[1];
  assign osc_en      = cfg_q.enable;
  assign calib_val   = cfg_q.trim;
  assign ondemand_o  = cfg_q.ondemand;
  assign stdby_run_o = cfg_q.stdby_run;

endmodule

// File: rtl/osc_ctl_chk.sv
module osc_ctl_chk
  import osc_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned REG_ADDR = 'h18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              lp_tick,
  input logic              osc_en,
  input logic              osc_ready,
  input logic              clk_main_en,
  input logic              clk_div_en,
  input logic              lock,
  input logic [31:0]       word
);

  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(REG_ADDR)) |-> ((bus_rdata & ~CFG_MASK) == 32'h0));

  assert_other_addr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(REG_ADDR)) |-> (bus_rdata == 32'h0));

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  assert_locked_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(word));

  assert_ready_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_ready) |-> $past(lp_tick));

  assert_ready_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    osc_ready |-> osc_en);

  assert_main_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_main_en |-> osc_ready);

  assert_div_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_div_en |-> osc_ready);

endmodule

bind osc_ctl_top osc_ctl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .lp_tick    (lp_tick),
  .osc_en     (osc_en),
  .osc_ready  (osc_ready),
  .clk_main_en(clk_main_en),
  .clk_div_en (clk_div_en),
  .lock       (cfg_q.lock),
  .word       (cfg_word)
);

// File: tb/test_osc_ctl_top.sv
module test_osc_ctl_top;

  localparam int unsigned ADDR_W = 8;
  localparam logic [7:0]  RA     = 8'h18;
  localparam logic [31:0] MASK   = 32'h007F_17CE;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        lp_tick;
  logic        osc_en, osc_ready, clk_main_en, clk_div_en;
  logic [6:0]  calib_val;
  logic        ondemand_o, stdby_run_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  osc_ctl_top #(.ADDR_W(ADDR_W), .REG_ADDR(32'h18), .CNT_W(8)) i_osc_ctl_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lp_tick(lp_tick),
    .osc_en(osc_en), .osc_ready(osc_ready), .clk_main_en(clk_main_en),
    .clk_div_en(clk_div_en), .calib_val(calib_val), .ondemand_o(ondemand_o),
    .stdby_run_o(stdby_run_o)
  );

  function automatic int exp_edges(input int code);
    int t;
    case (code)
      0: t = 3;   1: t = 4;   2: t = 6;   3: t = 10;
      4: t = 18;  5: t = 34;  6: t = 66;  default: t = 130;
    endcase
    return t + 3;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = RA; bus_wdata = '0; lp_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    #1;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    lp_tick = 1'b1;
    @(negedge clk);
    lp_tick = 1'b0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd, exp_reg, d;
    logic [7:0]  a;
    int          t;
    void'($urandom(32'd1234));
    do_reset();

    // R1 reset state
    bus_read(RA, rd);
    check("R1 reset value", rd, 32'h003F_0080);
    check("R1 ready low", {osc_ready, clk_main_en, clk_div_en}, 3'b000);
    check("R10 reset pins", {osc_en, calib_val, ondemand_o, stdby_run_o}, {1'b0, 7'h3F, 1'b1, 1'b0});

    // R2 R3 R4 R10 random writes without strobes, lock bit held clear
    exp_reg = 32'h003F_0080;
    for (int i = 0; i < 60; i++) begin
      d = $urandom() & ~32'h0000_1000;
      a = ($urandom() % 2 == 0) ? RA : 8'($urandom());
      bus_write(a, d);
      if (a == RA) exp_reg = d & MASK;
      bus_read(RA, rd);
      check("R2 R3 R4 readback", rd, exp_reg);
      check("R10 pins", {osc_en, calib_val, ondemand_o, stdby_run_o},
            {exp_reg[1], exp_reg[22:16], exp_reg[7], exp_reg[6]});
      check("R9 outputs held low", {clk_main_en, clk_div_en}, 2'b00);
      a = 8'($urandom());
      bus_read(a, rd);
      check("R4 other address reads zero", rd, (a == RA) ? exp_reg : 32'h0);
    end
    bus_write(RA, 32'h0);

    // R6 R7 R9 every start-up code
    for (int code = 0; code < 8; code++) begin
      logic m, v;
      m = code[0] | (code == 7);
      v = ~code[0] | (code == 7);
      t = exp_edges(code);
      bus_write(RA, (32'(code) << 8) | (32'(v) << 3) | (32'(m) << 2) | 32'h2);
      for (int k = 1; k < t; k++) tick();
      check($sformatf("R6 R7 not ready one before, code %0d", code), {osc_ready, clk_main_en, clk_div_en}, 3'b000);
      tick();
      check($sformatf("R6 ready at count, code %0d", code), osc_ready, 1'b1);
      check($sformatf("R9 gated outputs, code %0d", code), {clk_main_en, clk_div_en}, {m, v});
      bus_write(RA, 32'h0);
      check("R8 ready drops on disable", {osc_ready, clk_main_en, clk_div_en}, 3'b000);
    end

    // R8 disable mid-count, then full restart
    t = exp_edges(2);
    bus_write(RA, 32'h0000_020E);
    for (int k = 0; k < t - 2; k++) tick();
    bus_write(RA, 32'h0000_020C);
    check("R8 disabled mid-count", osc_ready, 1'b0);
    bus_write(RA, 32'h0000_020E);
    for (int k = 1; k < t; k++) tick();
    check("R8 restart needs full count", osc_ready, 1'b0);
    tick();
    check("R8 restart ready", {osc_ready, clk_main_en, clk_div_en}, 3'b111);
    bus_write(RA, 32'h0000_020C);
    #1;
    check("R8 ready low same edge", {osc_en, osc_ready}, 2'b00);

    // R5 lock applies its own write, then freezes
    bus_write(RA, 32'h0012_1046);
    bus_read(RA, rd);
    check("R5 locking write applied", rd, 32'h0012_1046);
    bus_write(RA, 32'h0055_03CE);
    bus_read(RA, rd);
    check("R5 later write ignored", rd, 32'h0012_1046);
    bus_write(RA, 32'h0000_0000);
    bus_read(RA, rd);
    check("R5 lock not clearable", rd, 32'h0012_1046);
    do_reset();
    bus_read(RA, rd);
    check("R5 reset clears lock", rd, 32'h003F_0080);
    bus_write(RA, 32'h0001_0000);
    bus_read(RA, rd);
    check("R5 writable after reset", rd, 32'h0001_0000);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule